// File: doc/BRIEF.md
# Ultra DMA Write-Burst Receiver

This block is the device-side receive path for a host-to-device Ultra DMA data-out burst. It takes the raw host strobe, the host STOP line and the 16-bit data bus. It brings them into the fast system clock domain through a two-flop synchroniser. One data word is captured on every strobe transition, rising or falling. The captured words are pushed into a small internal FIFO. A downstream consumer empties that FIFO through a plain ready/valid port.

The block throttles the host through an active-low device-ready output. That output is asserted only while a burst is active and the FIFO still has more free slots than a programmable threshold. The threshold is never allowed below four words. A running CRC and a word count cover every word received in the burst. When the host raises STOP, the block emits a single-cycle completion pulse carrying the final CRC and the count. Firmware can then compare that CRC with the one the host sends. After the pulse, the block ignores the strobe until the next burst-enable.

Top module: `udma_wr_rx`

## Requirements
- R1: While reset is held and on release, `dev_ready_n` is 1 and `out_valid`, `burst_done` and `overflow` are 0.
- R2: While a burst is active, every transition of `host_strobe`, rising or falling, captures the value on `host_data` as one 16-bit word. Captured words leave on the drain port in arrival order.
- R3: A burst with no strobe transitions is a pause. For any length of pause, no word is captured, `burst_done` stays 0 and `dev_ready_n` keeps its value.
- R4: When `host_stop` is seen high during an active burst, `burst_done` is 1 for exactly one cycle. In that cycle `burst_words` holds the number of words received in the burst and `burst_crc` holds the final CRC.
- R5: After a burst ends, strobe transitions capture nothing until the next rising edge of `burst_en`. `host_stop` while no burst is active produces no `burst_done`.
- R6: `dev_ready_n` is 0 (ready) only while a burst is active and the FIFO free space exceeds max(`room_thresh`, 4). Otherwise it is 1.
- R7: The CRC uses polynomial x^16+x^12+x^5+1 (0x1021) and is processed MSB-first over each 16-bit word. It is reseeded to 16'h4ABA at burst start and updated with every received word, dropped words included.
- R8: A word that arrives while the FIFO holds FIFO_DEPTH words is dropped but still counted. It sets `overflow`, which stays 1 until the next burst start.
- R9: A FIFO word is removed exactly when `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Rising edge opens a write burst |
| host_strobe | input | 1 | Raw host data strobe, both edges significant |
| host_stop | input | 1 | Raw host STOP, ends the burst |
| host_data | input | DW | Raw host data bus |
| room_thresh | input | log2(FIFO_DEPTH)+1 | Free-space level at or below which the host is paused |
| dev_ready_n | output | 1 | Active-low device ready toward the host |
| out_valid | output | 1 | FIFO head word is valid |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | DW | FIFO head word |
| burst_done | output | 1 | One-cycle end-of-burst pulse |
| burst_crc | output | 16 | Final burst CRC, valid with `burst_done` |
| burst_words | output | CNT_W | Words received in the burst, valid with `burst_done` |
| overflow | output | 1 | Sticky flag for dropped words |

## Verification
The bench builds the block with FIFO_DEPTH=8, keeping DW=16 and CNT_W=16. An eight-entry FIFO lets a short burst fill it completely, so the drop path and the sticky flag are exercised within a few words. With this depth, a threshold of 5 and a threshold of 2 give different pause points. The threshold of 2 is raised to the four-word floor. This shows both the programmed and the floored cases of the ready rule. Word order and content are compared against a queue model on every clock as words leave the FIFO, and the CRC is computed independently.

// File: rtl/udma_wr_pkg.sv
package udma_wr_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } rx_state_e;

  // One 16-bit word folded into the CRC, most significant bit first.
  function automatic logic [15:0] crc16_word(input logic [15:0] crc_in,
                                             input logic [15:0] word);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ word[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/udma_wr_sync.sv
module udma_wr_sync #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_in,
  input  logic          stop_in,
  input  logic [DW-1:0] data_in,
  output logic          edge_o,
  output logic          stop_o,
  output logic [DW-1:0] word_o
);

  logic [2:0]    stb_q, stb_d;
  logic [1:0]    stp_q, stp_d;
  logic [DW-1:0] dat1_q, dat1_d;
  logic [DW-1:0] dat2_q, dat2_d;

  always_comb begin
    stb_d  = {stb_q[1:0], strobe_in};
    stp_d  = {stp_q[0], stop_in};
    dat1_d = data_in;
    dat2_d = dat1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= '0;
      stp_q  <= '0;
      dat1_q <= '0;
      dat2_q <= '0;
    end else begin
      stb_q  <= stb_d;
      stp_q  <= stp_d;
      dat1_q <= dat1_d;
      dat2_q <= dat2_d;
    end
  end

  // A transition is two successive synchronised samples that differ; the
  // data word synchronised alongside the newer sample is the one reported.
  assign edge_o = stb_q[1] ^ stb_q[2];
  assign stop_o = stp_q[1];
  assign word_o = dat2_q;

  // R2: an edge report is always followed by the strobe holding its new level
  a_r2_edge_settles: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (stb_q[2] == $past(stb_q[1])));

endmodule

// File: rtl/udma_wr_fifo.sv
module udma_wr_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop_ready,
  output logic                     out_valid,
  output logic [DW-1:0]            out_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;
  logic          do_push, do_pop;

  assign full      = (level_q == LW'(DEPTH));
  assign out_valid = (level_q != '0);
  assign out_data  = mem[rd_ptr_q];
  assign level     = level_q;

  assign do_push = push & ~full;
  assign do_pop  = out_valid & pop_ready;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  // R9: occupancy moves by at most one word per cycle
  a_r9_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((level_q == $past(level_q)) ||
              (level_q == $past(level_q) + 1'b1) ||
              (level_q + 1'b1 == $past(level_q))));

  // R8: a full FIFO that is not read stays full, whatever is pushed
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ready) |=> full);

endmodule

// File: rtl/udma_wr_crc.sv
module udma_wr_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [15:0] word,
  output logic [15:0] crc_q,
  output logic [15:0] crc_upd
);
  import udma_wr_pkg::*;

  logic [15:0] crc_d;

  assign crc_upd = crc16_word(crc_q, word);

  always_comb begin
    crc_d = crc_q;
    if (clear)   crc_d = CRC_SEED;
    else if (en) crc_d = crc_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  // R7: a clear always leaves the seed in the register
  a_r7_crc_seeded: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/udma_wr_rx.sv
module udma_wr_rx #(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16,
  parameter int MIN_ROOM   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         burst_en,
  input  logic                         host_strobe,
  input  logic                         host_stop,
  input  logic [DW-1:0]                host_data,
  input  logic [$clog2(FIFO_DEPTH):0]  room_thresh,
  output logic                         dev_ready_n,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DW-1:0]                out_data,
  output logic                         burst_done,
  output logic [15:0]                  burst_crc,
  output logic [CNT_W-1:0]             burst_words,
  output logic                         overflow
);
  import udma_wr_pkg::*;

  localparam int LW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(FIFO_DEPTH);
  localparam logic [LW-1:0] FLOOR_L = LW'(MIN_ROOM);

  // synchronised host side
  logic          s_edge, s_stop;
  logic [DW-1:0] s_word;

  udma_wr_sync #(.DW(DW)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_in (host_strobe),
    .stop_in   (host_stop),
    .data_in   (host_data),
    .edge_o    (s_edge),
    .stop_o    (s_stop),
    .word_o    (s_word)
  );

  // control state
  rx_state_e        state_q, state_d;
  logic             en_q;
  logic             start, capture, push, finish;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             done_q, done_d;
  logic [15:0]      dcrc_q, dcrc_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             fifo_full;
  logic [LW-1:0]    fifo_level;
  logic [LW-1:0]    free_room, eff_thresh;
  logic [15:0]      crc_q, crc_upd;

  assign start   = burst_en & ~en_q & (state_q == ST_IDLE);
  assign capture = (state_q == ST_ACTIVE) & s_edge;
  assign push    = capture & ~fifo_full;
  assign finish  = (state_q == ST_ACTIVE) & s_stop;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    dcrc_d  = dcrc_q;
    dcnt_d  = dcnt_q;
    if (start) begin
      state_d = ST_ACTIVE;
      cnt_d   = '0;
      ovf_d   = 1'b0;
    end else begin
      if (capture) cnt_d = cnt_q + 1'b1;
      if (capture && fifo_full) ovf_d = 1'b1;
      if (finish) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        dcnt_d  = cnt_q + CNT_W'(capture);
        dcrc_d  = capture ? crc_upd : crc_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      dcrc_q  <= CRC_SEED;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= burst_en;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
      dcrc_q  <= dcrc_d;
      dcnt_q  <= dcnt_d;
    end
  end

  udma_wr_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .en      (capture),
    .word    (s_word),
    .crc_q   (crc_q),
    .crc_upd (crc_upd)
  );

  udma_wr_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (s_word),
    .pop_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .level     (fifo_level),
    .full      (fifo_full)
  );

  // flow control toward the host
  assign free_room   = DEPTH_L - fifo_level;
  assign eff_thresh  = (room_thresh < FLOOR_L) ? FLOOR_L : room_thresh;
  assign dev_ready_n = ~((state_q == ST_ACTIVE) && (free_room > eff_thresh));

  assign burst_done  = done_q;
  assign burst_crc   = dcrc_q;
  assign burst_words = dcnt_q;
  assign overflow    = ovf_q;

  // R4: completion only ever follows an active burst
  a_r4_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> ($past(state_q) == ST_ACTIVE));

  // R4: the completion pulse lasts a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R6: ready toward the host always leaves the minimum headroom
  a_r6_headroom: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ready_n |-> (free_room > FLOOR_L));

  // R8: overflow persists until a new burst begins
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow);

  // R5: nothing enters the FIFO outside a burst
  a_r5_no_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !push);

endmodule

// File: tb/udma_wr_rx_tb.sv
module udma_wr_rx_tb;

  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          burst_en, host_strobe, host_stop, out_ready;
  logic [DW-1:0] host_data;
  logic [LW-1:0] room_thresh;
  logic          dev_ready_n, out_valid, burst_done, overflow;
  logic [DW-1:0] out_data;
  logic [15:0]   burst_crc;
  logic [CW-1:0] burst_words;

  always #2 clk = ~clk;

  udma_wr_rx #(.DW(DW), .FIFO_DEPTH(DEPTH), .CNT_W(CW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_en    (burst_en),
    .host_strobe (host_strobe),
    .host_stop   (host_stop),
    .host_data   (host_data),
    .room_thresh (room_thresh),
    .dev_ready_n (dev_ready_n),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .burst_done  (burst_done),
    .burst_crc   (burst_crc),
    .burst_words (burst_words),
    .overflow    (overflow)
  );

  int errs = 0;
  int checks = 0;
  int done_cnt = 0;
  bit finished = 0;
  logic [15:0]   last_crc;
  logic [CW-1:0] last_count;
  logic [15:0]   expq[$];
  logic [15:0]   m_crc;
  int            m_count;

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] != d[i]) r = (r << 1) ^ 16'h1021;
      else               r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model compared on every clock: drained words against the queue
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R9", "unexpected drained word", int'(out_data), 0);
        else begin
          logic [15:0] w;
          w = expq.pop_front();
          chk(out_data == w, "R2", "drained word", int'(out_data), int'(w));
        end
      end
      if (burst_done) begin
        done_cnt++;
        last_crc   = burst_crc;
        last_count = burst_words;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [15:0] w, input bit keep);
    host_data = w;
    cyc(1);
    host_strobe = ~host_strobe;
    m_count++;
    m_crc = ref_crc(m_crc, w);
    if (keep) expq.push_back(w);
    cyc(4);
  endtask

  task automatic open_burst();
    burst_en = 1'b1;
    cyc(2);
    burst_en = 1'b0;
    cyc(2);
    m_crc = 16'h4ABA;
    m_count = 0;
  endtask

  task automatic close_burst();
    int d0;
    d0 = done_cnt;
    host_stop = 1'b1;
    cyc(6);
    host_stop = 1'b0;
    cyc(3);
    chk(done_cnt == d0 + 1, "R4", "done pulse count", done_cnt - d0, 1);
    chk(last_count == CW'(m_count), "R4", "word count", int'(last_count), m_count);
    chk(last_crc == m_crc, "R7", "burst crc", int'(last_crc), int'(m_crc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    burst_en = 1'b0;
    host_strobe = 1'b0;
    host_stop = 1'b0;
    host_data = '0;
    room_thresh = LW'(5);
    out_ready = 1'b1;
    m_crc = 16'h4ABA;
    m_count = 0;
    cyc(3);
    chk(dev_ready_n == 1'b1, "R1", "ready in reset", int'(dev_ready_n), 1);
    chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(burst_done == 1'b0, "R1", "done after reset", int'(burst_done), 0);
    chk(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);
    chk(dev_ready_n == 1'b1, "R6", "ready while idle", int'(dev_ready_n), 1);

    // burst with free drain, several data patterns and a long pause
    open_burst();
    chk(dev_ready_n == 1'b0, "R6", "ready in burst", int'(dev_ready_n), 0);
    send(16'h0000, 1); send(16'hFFFF, 1); send(16'hA5A5, 1);
    send(16'h5A5A, 1); send(16'h1234, 1); send(16'h8001, 1);
    begin
      int d0;
      d0 = done_cnt;
      cyc(60);
      chk(done_cnt == d0, "R3", "no done during pause", done_cnt - d0, 0);
      chk(dev_ready_n == 1'b0, "R3", "ready held in pause", int'(dev_ready_n), 0);
    end
    send(16'hBEEF, 1); send(16'h0F0F, 1);
    close_burst();
    chk(expq.size() == 0, "R2", "all words drained", expq.size(), 0);
    chk(dev_ready_n == 1'b1, "R6", "ready after stop", int'(dev_ready_n), 1);

    // edges and stop while idle
    begin
      int d0;
      d0 = done_cnt;
      for (int k = 0; k < 3; k++) begin
        host_data = 16'h7777 + 16'(k);
        cyc(1);
        host_strobe = ~host_strobe;
        cyc(4);
      end
      chk(out_valid == 1'b0, "R5", "no capture when idle", int'(out_valid), 0);
      host_stop = 1'b1;
      cyc(6);
      host_stop = 1'b0;
      cyc(3);
      chk(done_cnt == d0, "R5", "no done when idle", done_cnt - d0, 0);
    end

    // threshold behaviour with drain held off
    out_ready = 1'b0;
    room_thresh = LW'(5);
    open_burst();
    send(16'h1111, 1); send(16'h2222, 1);
    chk(dev_ready_n == 1'b0, "R6", "free 6 over thresh 5", int'(dev_ready_n), 0);
    send(16'h3333, 1);
    chk(dev_ready_n == 1'b1, "R6", "free 5 at thresh 5", int'(dev_ready_n), 1);
    room_thresh = LW'(2);
    cyc(1);
    chk(dev_ready_n == 1'b0, "R6", "free 5 over floor 4", int'(dev_ready_n), 0);
    send(16'h4444, 1);
    chk(dev_ready_n == 1'b1, "R6", "free 4 at floor", int'(dev_ready_n), 1);
    out_ready = 1'b1;
    cyc(10);
    chk(dev_ready_n == 1'b0, "R9", "ready after drain", int'(dev_ready_n), 0);
    chk(expq.size() == 0, "R9", "drained in order", expq.size(), 0);
    close_burst();

    // overflow: ten words into eight slots
    out_ready = 1'b0;
    open_burst();
    for (int k = 0; k < 10; k++) send(16'hC000 + 16'(k * 3), k < DEPTH);
    chk(overflow == 1'b1, "R8", "overflow set", int'(overflow), 1);
    close_burst();
    chk(overflow == 1'b1, "R8", "overflow sticky", int'(overflow), 1);
    out_ready = 1'b1;
    cyc(12);
    chk(expq.size() == 0, "R8", "kept words drained", expq.size(), 0);
    open_burst();
    chk(overflow == 1'b0, "R8", "overflow cleared at start", int'(overflow), 0);
    close_burst();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule